// File: doc/BRIEF.md
# AXI Write Address/Data Join Unit

This block is the receiving front end of an AXI4 write path. Address beats and data beats arrive on their own channels in any relative order. The block pairs each address with one data burst and turns each pair into single-beat writes on a plain memory-style port. It then returns one write response per pairing. Data may arrive ahead of its address. Such data waits in a bounded beat buffer, and accepted addresses wait in a bounded address queue. Only incrementing bursts of full-width beats with a single transaction ID are handled.

The `err_policy` input decides what happens when the beat buffer is full while no address is waiting and no burst is being written. With `err_policy` low, the data channel is stalled. With `err_policy` high, the offending burst is taken in and thrown away through its last beat. The next address to be paired with it receives an error response. Further data is held off until that error has been issued.

Pairing is strictly first-come: the oldest queued address owns the oldest buffered burst. A burst whose beat count disagrees with its address's length field is still consumed in full, but it receives an error response.

Top module: `wr_join_unit`

## Requirements
- R1: Data beats are accepted while the beat buffer holds fewer than DQ_DEPTH beats, whether or not any address has arrived.
- R2: The back end sees no write until an address has been taken from the address queue. The first beat of a burst is written no earlier than the cycle after that address was taken.
- R3: `aw_ready` is low whenever AQ_DEPTH addresses are waiting in the address queue.
- R4: With `err_policy` = 0 and the beat buffer full, `w_ready` is low until a beat leaves the buffer.
- R5: With `err_policy` = 1, a beat offered while the buffer is full, the address queue is empty and no burst is in progress is accepted and discarded. The rest of that burst, through `w_last`, is also discarded. The next address to be paired returns SLVERR and causes no back-end write. `w_ready` stays low from the last discarded beat until that response is queued.
- R6: Addresses and bursts are paired in arrival order.
- R7: Beat k of a burst (k counting from 0) is written with `mem_addr` = address + k·(DATA_W/8), modulo 2^ADDR_W. It carries that beat's data and byte strobes.
- R8: If the number of beats up to and including `w_last` differs from `aw_len`+1, the response is SLVERR. Beats past `aw_len`+1 are consumed but not written.
- R9: Each response is issued only after its address and its last beat have been consumed, and responses are issued in pairing order. `b_resp` is 2'b00 for OKAY and 2'b10 for SLVERR.
- R10: Once `b_valid` is high, it and `b_resp` hold their values until a cycle in which `b_ready` is high.
- R11: A synchronous low `rst_n` empties all queues, drops any pending response or discard state, and drives `aw_ready`, `w_ready`, `b_valid` and `mem_we` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| err_policy | input | 1 | Overflow policy: 0 stall, 1 discard with error |
| aw_valid | input | 1 | Address beat valid |
| aw_ready | output | 1 | Address beat accepted |
| aw_addr | input | ADDR_W | Burst start byte address |
| aw_len | input | 8 | Burst length minus one |
| w_valid | input | 1 | Data beat valid |
| w_ready | output | 1 | Data beat accepted |
| w_data | input | DATA_W | Beat data |
| w_strb | input | DATA_W/8 | Beat byte strobes |
| w_last | input | 1 | Final beat of a burst |
| b_valid | output | 1 | Response valid |
| b_ready | input | 1 | Response accepted |
| b_resp | output | 2 | Response code |
| mem_we | output | 1 | Back-end write enable |
| mem_addr | output | ADDR_W | Back-end beat address |
| mem_wdata | output | DATA_W | Back-end write data |
| mem_wstrb | output | DATA_W/8 | Back-end byte strobes |

## Verification
If the address queue and the beat buffer drift out of step, the mismatch appears at the back end in the same cycle the wrong beat is popped. It shows up as a wrong `mem_addr`, wrong data or a wrong `mem_we`. A lost or extra response appears on `b_resp` in the cycle after the pairing ends. A stale discard state shows up as a `w_ready` that stays low, or as an error response on a well-formed burst. Because of this, the ready, write and response pins are compared against an independent model on every cycle, so any divergence is caught at its first visible cycle.

// File: rtl/wj_pkg.sv
package wj_pkg;

  localparam int LEN_W = 8;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_SLVERR = 2'b10
  } bresp_e;

  typedef enum logic {
    ENG_IDLE,
    ENG_BURST
  } eng_state_e;

  // beat index idx (0-based) still lies inside a burst of len+1 beats
  function automatic logic beat_in_range(logic [LEN_W:0] idx, logic [LEN_W-1:0] len);
    return idx <= {1'b0, len};
  endfunction

  // index of the last beat equals the announced length field
  function automatic logic len_matches(logic [LEN_W:0] idx, logic [LEN_W-1:0] len);
    return idx == {1'b0, len};
  endfunction

endpackage

// File: rtl/wj_fifo.sv
module wj_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/wj_intake.sv
module wj_intake (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic err_policy,
  input  logic w_valid,
  input  logic w_last,
  input  logic dq_full,
  input  logic addr_idle,
  input  logic drop_clear,
  output logic w_ready,
  output logic dq_push,
  output logic w_drop,
  output logic drop_done
);
  logic drop_act;
  logic ovf;
  logic w_fire;

  // overflow with no address to drain the buffer: discard under error policy
  assign ovf     = err_policy & dq_full & addr_idle;
  assign w_ready = live & ~drop_done & (drop_act | ~dq_full | ovf);
  assign w_fire  = w_valid & w_ready;
  assign w_drop  = w_fire & (drop_act | dq_full);
  assign dq_push = w_fire & ~w_drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_act  <= 1'b0;
      drop_done <= 1'b0;
    end else begin
      if (w_drop) drop_act <= ~w_last;
      if (w_drop & w_last)  drop_done <= 1'b1;
      else if (drop_clear)  drop_done <= 1'b0;
    end
  end
endmodule

// File: rtl/wj_engine.sv
module wj_engine
  import wj_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aq_valid,
  input  logic [ADDR_W-1:0] aq_addr,
  input  logic [LEN_W-1:0]  aq_len,
  input  logic              bq_full,
  input  logic              dq_valid,
  input  logic              dq_last,
  input  logic              drop_done,
  output logic              aq_pop,
  output logic              dq_pop,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              bq_push,
  output logic [1:0]        bq_resp,
  output logic              drop_clear,
  output logic              busy
);
  localparam int BYTES = DATA_W / 8;
  localparam int SHIFT = $clog2(BYTES);
  localparam int CNT_W = LEN_W + 1;

  eng_state_e        state;
  logic [ADDR_W-1:0] base;
  logic [LEN_W-1:0]  len;
  logic [CNT_W-1:0]  idx;

  function automatic logic [ADDR_W-1:0] beat_address(logic [ADDR_W-1:0] b, logic [CNT_W-1:0] k);
    return b + (ADDR_W'(k) << SHIFT);
  endfunction

  assign busy       = (state == ENG_BURST);
  assign aq_pop     = ~busy & aq_valid & ~bq_full;
  assign dq_pop     = busy & dq_valid;
  assign mem_we     = dq_pop & beat_in_range(idx, len);
  assign mem_addr   = beat_address(base, idx);
  assign drop_clear = busy & ~dq_valid & drop_done;
  assign bq_push    = (dq_pop & dq_last) | drop_clear;
  assign bq_resp    = (drop_clear || !len_matches(idx, len)) ? RESP_SLVERR : RESP_OKAY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ENG_IDLE;
      base  <= '0;
      len   <= '0;
      idx   <= '0;
    end else if (aq_pop) begin
      state <= ENG_BURST;
      base  <= aq_addr;
      len   <= aq_len;
      idx   <= '0;
    end else if (bq_push) begin
      state <= ENG_IDLE;
    end else if (dq_pop && idx != '1) begin
      idx <= idx + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wr_join_unit.sv
module wr_join_unit
  import wj_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int AQ_DEPTH = 4,
  parameter int DQ_DEPTH = 8,
  localparam int STRB_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_policy,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [7:0]        aw_len,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic [DATA_W-1:0] w_data,
  input  logic [STRB_W-1:0] w_strb,
  input  logic              w_last,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [1:0]        b_resp,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [STRB_W-1:0] mem_wstrb
);
  localparam int AQ_W  = ADDR_W + LEN_W;
  localparam int DQ_W  = DATA_W + STRB_W + 1;
  localparam int AQ_CW = $clog2(AQ_DEPTH + 1);
  localparam int DQ_CW = $clog2(DQ_DEPTH + 1);

  logic live;
  always_ff @(posedge clk) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  // address queue
  logic             aq_push, aq_pop, aq_empty, aq_full;
  logic [AQ_W-1:0]  aq_dout;
  logic [AQ_CW-1:0] aq_count;

  assign aw_ready = live & ~aq_full;
  assign aq_push  = aw_valid & aw_ready;

  wj_fifo #(.WIDTH(AQ_W), .DEPTH(AQ_DEPTH)) u_aq (
    .clk(clk), .rst_n(rst_n), .push(aq_push), .din({aw_addr, aw_len}),
    .pop(aq_pop), .dout(aq_dout), .count(aq_count), .empty(aq_empty), .full(aq_full)
  );

  // beat buffer
  logic             dq_push, dq_pop, dq_empty, dq_full;
  logic [DQ_W-1:0]  dq_dout;
  logic [DQ_CW-1:0] dq_count;

  wj_fifo #(.WIDTH(DQ_W), .DEPTH(DQ_DEPTH)) u_dq (
    .clk(clk), .rst_n(rst_n), .push(dq_push), .din({w_data, w_strb, w_last}),
    .pop(dq_pop), .dout(dq_dout), .count(dq_count), .empty(dq_empty), .full(dq_full)
  );

  assign mem_wdata = dq_dout[DQ_W-1 -: DATA_W];
  assign mem_wstrb = dq_dout[STRB_W:1];

  // response queue, one slot per outstanding address
  logic             bq_push, bq_empty, bq_full;
  logic [1:0]       bq_resp;
  logic [AQ_CW-1:0] bq_count;

  wj_fifo #(.WIDTH(2), .DEPTH(AQ_DEPTH)) u_bq (
    .clk(clk), .rst_n(rst_n), .push(bq_push), .din(bq_resp),
    .pop(b_valid & b_ready), .dout(b_resp), .count(bq_count), .empty(bq_empty), .full(bq_full)
  );

  assign b_valid = ~bq_empty;

  // intake policy and burst engine
  logic eng_busy, w_drop, drop_done, drop_clear;

  wj_intake u_intake (
    .clk(clk), .rst_n(rst_n), .live(live), .err_policy(err_policy),
    .w_valid(w_valid), .w_last(w_last), .dq_full(dq_full),
    .addr_idle(aq_empty & ~eng_busy), .drop_clear(drop_clear),
    .w_ready(w_ready), .dq_push(dq_push), .w_drop(w_drop), .drop_done(drop_done)
  );

  wj_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .aq_valid(~aq_empty), .aq_addr(aq_dout[AQ_W-1 -: ADDR_W]), .aq_len(aq_dout[LEN_W-1:0]),
    .bq_full(bq_full), .dq_valid(~dq_empty), .dq_last(dq_dout[0]), .drop_done(drop_done),
    .aq_pop(aq_pop), .dq_pop(dq_pop), .mem_we(mem_we), .mem_addr(mem_addr),
    .bq_push(bq_push), .bq_resp(bq_resp), .drop_clear(drop_clear), .busy(eng_busy)
  );
endmodule

// File: rtl/wj_checker.sv
module wj_checker #(
  parameter int AQ_DEPTH = 4,
  parameter int DQ_DEPTH = 8,
  localparam int AQ_CW = $clog2(AQ_DEPTH + 1),
  localparam int DQ_CW = $clog2(DQ_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             err_policy,
  input logic             aw_ready,
  input logic             w_ready,
  input logic             w_last,
  input logic             b_valid,
  input logic             b_ready,
  input logic [1:0]       b_resp,
  input logic             mem_we,
  input logic [AQ_CW-1:0] aq_count,
  input logic [DQ_CW-1:0] dq_count,
  input logic             dq_full,
  input logic             eng_busy,
  input logic             w_drop,
  input logic             bq_push
);
  a_r1_buffer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(dq_count) <= DQ_DEPTH);

  a_r2_write_needs_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> eng_busy);

  a_r3_aw_block_full: assert property (@(posedge clk) disable iff (!rst_n)
    int'(aq_count) == AQ_DEPTH |-> !aw_ready);

  a_r4_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
    !err_policy && dq_full |-> !w_ready);

  a_r5_hold_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
    w_drop && w_last |=> !w_ready);

  a_r9_resp_from_engine: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_valid) |-> $past(bq_push));

  a_r10_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid && !b_ready |=> b_valid && $stable(b_resp));

  a_r11_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !aw_ready && !w_ready && !b_valid && !mem_we);
endmodule

bind wr_join_unit wj_checker #(.AQ_DEPTH(AQ_DEPTH), .DQ_DEPTH(DQ_DEPTH)) u_wj_checker (
  .clk(clk), .rst_n(rst_n), .err_policy(err_policy), .aw_ready(aw_ready),
  .w_ready(w_ready), .w_last(w_last), .b_valid(b_valid), .b_ready(b_ready),
  .b_resp(b_resp), .mem_we(mem_we), .aq_count(aq_count), .dq_count(dq_count),
  .dq_full(dq_full), .eng_busy(eng_busy), .w_drop(w_drop), .bq_push(bq_push)
);

// File: tb/test_wr_join_unit.sv
module test_wr_join_unit;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int AQ = 4;
  localparam int DQ = 8;
  localparam int SB = DATA_W / 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, err_policy = 1'b0;
  logic aw_valid = 1'b0, w_valid = 1'b0, w_last = 1'b0, b_ready = 1'b1;
  logic [ADDR_W-1:0] aw_addr = '0;
  logic [7:0] aw_len = '0;
  logic [DATA_W-1:0] w_data = '0;
  logic [SB-1:0] w_strb = '0;
  logic aw_ready, w_ready, b_valid, mem_we;
  logic [1:0] b_resp;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [SB-1:0] mem_wstrb;

  wr_join_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AQ_DEPTH(AQ), .DQ_DEPTH(DQ)) i_wr_join_unit (
    .clk(clk), .rst_n(rst_n), .err_policy(err_policy),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  typedef struct {int addr; int len;} aw_t;
  typedef struct {int data; int strb; bit last;} wb_t;

  aw_t aq_m[$];
  wb_t dq_m[$];
  int  bq_m[$];
  bit  m_live, m_busy, m_dact, m_ddone;
  int  m_addr, m_len, m_cnt;
  int  mem_seen[int];
  int  we_count = 0;
  int  exp_resp[$];
  string exp_tag[$];

  always @(negedge clk) begin : model
    bit awr, wr, full, ovf, bv, we_e, af, wf, dropb, bf, start;
    aw_t a_h;
    wb_t b_h;
    full = (dq_m.size() == DQ);
    awr  = m_live && aq_m.size() < AQ;
    ovf  = err_policy && full && aq_m.size() == 0 && !m_busy;
    wr   = m_live && !m_ddone && (m_dact || !full || ovf);
    bv   = bq_m.size() > 0;
    we_e = m_busy && dq_m.size() > 0 && m_cnt <= m_len;

    check(aw_ready === awr, "R3", "aw_ready", aw_ready, awr);
    check(w_ready === wr, full ? (err_policy ? "R5" : "R4") : "R1", "w_ready", w_ready, wr);
    check(b_valid === bv, "R9", "b_valid", b_valid, bv);
    if (bv) check(b_resp === 2'(bq_m[0]), "R10", "b_resp", b_resp, bq_m[0]);
    check(mem_we === we_e, "R2", "mem_we", mem_we, we_e);
    if (we_e) begin
      check(int'(mem_addr) === ((m_addr + m_cnt * SB) & 'hFFFF), "R7", "mem_addr", mem_addr, m_addr + m_cnt * SB);
      check(mem_wdata === 32'(dq_m[0].data), "R7", "mem_wdata", mem_wdata, dq_m[0].data);
      check(mem_wstrb === 4'(dq_m[0].strb), "R7", "mem_wstrb", mem_wstrb, dq_m[0].strb);
    end
    if (mem_we === 1'b1) begin
      mem_seen[int'(mem_addr)] = int'(mem_wdata);
      we_count++;
    end
    if (b_valid === 1'b1 && b_ready === 1'b1) begin
      if (exp_resp.size() == 0) check(1'b0, "R9", "unexpected response", b_resp, 0);
      else begin
        check(b_resp === 2'(exp_resp[0]), exp_tag[0], "response in order", b_resp, exp_resp[0]);
        void'(exp_resp.pop_front());
        void'(exp_tag.pop_front());
      end
    end

    if (!rst_n) begin
      aq_m.delete(); dq_m.delete(); bq_m.delete();
      m_live = 0; m_busy = 0; m_dact = 0; m_ddone = 0;
    end else begin
      af    = aw_valid && awr;
      wf    = w_valid && wr;
      dropb = wf && (m_dact || full);
      bf    = bv && b_ready;
      start = !m_busy && aq_m.size() > 0 && bq_m.size() < AQ;
      if (bf) void'(bq_m.pop_front());
      if (start) begin
        a_h = aq_m.pop_front();
        m_busy = 1; m_addr = a_h.addr; m_len = a_h.len; m_cnt = 0;
      end else if (m_busy) begin
        if (dq_m.size() > 0) begin
          b_h = dq_m.pop_front();
          if (b_h.last) begin
            bq_m.push_back(m_cnt == m_len ? 0 : 2);
            m_busy = 0;
          end
          m_cnt++;
        end else if (m_ddone) begin
          bq_m.push_back(2);
          m_busy = 0; m_ddone = 0;
        end
      end
      if (af) aq_m.push_back('{int'(aw_addr), int'(aw_len)});
      if (wf && !dropb) dq_m.push_back('{int'(w_data), int'(w_strb), w_last});
      if (dropb) begin
        if (w_last) begin m_ddone = 1; m_dact = 0; end
        else m_dact = 1;
      end
      m_live = 1;
    end
  end

  // ---------------- drivers ----------------
  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send_aw(int addr, int len);
    bit hs;
    aw_valid = 1'b1; aw_addr = ADDR_W'(addr); aw_len = 8'(len);
    do begin
      @(negedge clk); hs = aw_ready;
      @(posedge clk); #2;
    end while (!hs);
    aw_valid = 1'b0;
  endtask

  task automatic send_w(int base, int n);
    bit hs;
    for (int i = 0; i < n; i++) begin
      w_valid = 1'b1; w_data = DATA_W'(base + i); w_strb = SB'((i % 15) + 1); w_last = (i == n - 1);
      do begin
        @(negedge clk); hs = w_ready;
        @(posedge clk); #2;
      end while (!hs);
    end
    w_valid = 1'b0; w_last = 1'b0;
  endtask

  task automatic expect_resp(int r, string tag);
    exp_resp.push_back(r);
    exp_tag.push_back(tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin : main
    int wc;
    tick(3);
    check(aw_ready === 1'b0 && w_ready === 1'b0 && b_valid === 1'b0 && mem_we === 1'b0,
          "R11", "outputs in reset", {aw_ready, w_ready, b_valid, mem_we}, 0);
    rst_n = 1'b1;
    tick(2);

    // R6 basic pairing, address first
    expect_resp(0, "R6");
    fork send_aw('h100, 3); send_w('h1000, 4); join
    tick(10);
    check(mem_seen.exists('h10C) && mem_seen['h10C] == 'h1003, "R7", "beat 3 stored", mem_seen['h10C], 'h1003);

    // R1 R2 data ahead of address
    expect_resp(0, "R1");
    wc = we_count;
    send_w('h2000, 3);
    tick(10);
    check(we_count == wc, "R2", "no write before address", we_count, wc);
    check(w_ready === 1'b1, "R1", "w_ready with buffered data", w_ready, 1);
    send_aw('h200, 2);
    tick(10);
    check(mem_seen.exists('h208) && mem_seen['h208] == 'h2002, "R6", "late address pairs", mem_seen['h208], 'h2002);

    // R4 stall when buffer fills
    expect_resp(0, "R4");
    fork
      send_w('h3000, 10);
      begin
        tick(25);
        check(w_ready === 1'b0, "R4", "stall on full buffer", w_ready, 0);
        send_aw('h300, 9);
      end
    join
    tick(20);
    check(mem_seen.exists('h324) && mem_seen['h324] == 'h3009, "R7", "ten-beat burst end", mem_seen['h324], 'h3009);

    // R3 address queue limit
    for (int k = 0; k < 6; k++) expect_resp(0, "R3");
    for (int k = 0; k < 5; k++) send_aw('h400 + k * 16, 0);
    check(aw_ready === 1'b0, "R3", "address queue full", aw_ready, 0);
    fork
      send_aw('h460, 0);
      for (int k = 0; k < 6; k++) send_w('h4000 + k * 16, 1);
    join
    tick(20);

    // R8 length mismatch both ways
    expect_resp(2, "R8");
    expect_resp(2, "R8");
    fork send_aw('h500, 1); send_w('h5000, 3); join
    tick(10);
    check(!mem_seen.exists('h508), "R8", "excess beat not written", mem_seen.exists('h508), 0);
    check(mem_seen.exists('h504), "R8", "in-range beat written", mem_seen.exists('h504), 1);
    fork send_aw('h600, 3); send_w('h6000, 2); join
    tick(10);

    // R5 error policy: overflow burst discarded
    err_policy = 1'b1;
    expect_resp(0, "R5"); expect_resp(0, "R5"); expect_resp(2, "R5"); expect_resp(0, "R5");
    fork
      begin send_w('h7000, 4); send_w('h7100, 4); send_w('h7200, 3); send_w('h7300, 1); end
      begin
        tick(30);
        check(w_ready === 1'b0, "R5", "held off after discard", w_ready, 0);
        send_aw('h700, 3); send_aw('h720, 3); send_aw('h740, 2); send_aw('h760, 0);
      end
    join
    tick(20);
    check(!mem_seen.exists('h740), "R5", "discarded burst not written", mem_seen.exists('h740), 0);
    check(mem_seen.exists('h760) && mem_seen['h760] == 'h7300, "R5", "next burst after discard", mem_seen['h760], 'h7300);
    err_policy = 1'b0;

    // R10 response hold under backpressure
    b_ready = 1'b0;
    for (int k = 0; k < 5; k++) expect_resp(0, "R10");
    for (int k = 0; k < 5; k++) fork send_aw('h800 + k * 4, 0); send_w('h8000 + k, 1); join
    tick(20);
    check(b_valid === 1'b1 && b_resp === 2'b00, "R10", "response held", {b_valid, b_resp}, 4);
    b_ready = 1'b1;
    tick(20);

    // R11 reset drops a pending response
    b_ready = 1'b0;
    fork send_aw('h900, 0); send_w('h9000, 1); join
    tick(10);
    check(b_valid === 1'b1, "R9", "response pending", b_valid, 1);
    rst_n = 1'b0;
    tick(2);
    check(b_valid === 1'b0 && aw_ready === 1'b0, "R11", "reset clears response", {b_valid, aw_ready}, 0);
    rst_n = 1'b1;
    b_ready = 1'b1;
    tick(10);

    check(exp_resp.size() == 0, "R9", "all responses returned", exp_resp.size(), 0);
    finish_run();
  end
endmodule